// File: doc/BRIEF.md
# Keyed Power and Reset Controller for an Analog Peripheral

This block sits between a simple register bus and one analog peripheral. It decides whether the peripheral asks the system for power, whether it asks for its functional clock, and when it receives a reset. The bus has a word offset, 32-bit write data, a write strobe and a read strobe. Reads are combinational while the read strobe is high.

Two registers are guarded by unlock keys. Each key sits in bits 31:24 of the same write word, and each guarded register has a different key. The power-enable bit changes only with key 0x26. The reset-control register acts only with key 0xB1. A keyed reset command sends a one-cycle reset pulse to the peripheral. The pulse turns off the peripheral's on bit and sets a sticky flag. Software clears that flag only with a keyed write of 1.

The block also holds the following:
- a clock-request override;
- an automatic power-off option, which drops the enable request while the peripheral is idle;
- the peripheral's on bit;
- a read-only copy of the peripheral's ready line.

Word offsets: 0 power enable, 1 reset control, 2 reset status, 3 clock override, 4 auto power-off, 5 peripheral on, 6 ready status. Offset 7 and any offset above 6 are unmapped.

Top module: `perctl_top`

## Requirements
- R1: At offset 0, a write changes bit 0 (power enable, reset value 0) only when bits 31:24 of the same word equal 0x26. With any other key byte the write has no effect.
- R2: At offset 1, a write does nothing unless bits 31:24 equal 0xB1.
- R3: A keyed write to offset 1 with bit 0 = 1 drives `periph_rst_pulse` high for exactly the one cycle after the write edge. A keyed write with bit 0 = 0 produces no pulse.
- R4: The clock edge that ends a reset pulse clears the peripheral-on bit (offset 5 bit 0), so `periph_on` goes low.
- R5: The sticky flag reads at offset 2 bit 16. It is 0 after block reset, and it is set by the clock edge that ends a reset pulse.
- R6: A keyed write to offset 1 with bit 1 = 1 clears the sticky flag. Bit 1 = 0 has no effect. When a clear and the end of a pulse meet on the same edge, the flag ends up set.
- R7: Offset 3 has bit 0 = override enable and bit 1 = stop. With the override on, `clk_stop_req` equals the stop bit. With the override off, it follows `periph_auto_stop`.
- R8: Offset 4 bit 0 (auto power-off) resets to 1. `enable_req` is high when power is enabled and either auto power-off is 0 or `periph_idle` is 0.
- R9: Offset 5 bit 0 drives `periph_on` and resets to 0. Offset 6 bit 0 reads `periph_ready`, and writes to offset 6 are ignored.
- R10: The key byte, the whole of offset 1 and all reserved bits read as 0. Offsets above 6 read as 0, and writes to them change nothing.
- R11: `bus_rdata` is 0 whenever `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the register block |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |
| periph_idle | input | 1 | Peripheral reports idle |
| periph_auto_stop | input | 1 | Peripheral's own clock-stop request |
| periph_ready | input | 1 | Peripheral ready line |
| periph_rst_pulse | output | 1 | One-cycle reset to the peripheral |
| periph_on | output | 1 | Peripheral on control |
| clk_stop_req | output | 1 | Clock stop/gate request to the system |
| enable_req | output | 1 | Power enable request to the system |

## Verification
The bench attacks the keys with near-miss key bytes. A design that checked too few key bits, or swapped the two keys, would let the power bit move or let a pulse appear. It times the pulse edge by edge, so a pulse that lasts two cycles, or that clears the on bit and sets the sticky flag one edge early, shows up as a wrong value at a specific sample. It issues a keyed clear on the very edge that ends a pulse, so a design where the clear beats the set leaves the flag at 0. It also walks the auto-off truth table and both clock-override settings, and it checks that unmapped and guarded writes leave every readable register unchanged.

// File: rtl/perctl_pkg.sv
package perctl_pkg;

    localparam int DATA_W     = 32;
    localparam int KEY_LSB    = 24;
    localparam int KEY_W      = 8;
    localparam int STICKY_BIT = 16;

    localparam logic [KEY_W-1:0] PWR_KEY = 8'h26;
    localparam logic [KEY_W-1:0] RST_KEY = 8'hB1;

    typedef enum logic [2:0] {
        SEL_PWR  = 3'd0,
        SEL_RST  = 3'd1,
        SEL_STAT = 3'd2,
        SEL_CLK  = 3'd3,
        SEL_AUTO = 3'd4,
        SEL_CTL  = 3'd5,
        SEL_RDY  = 3'd6,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic pwr_wr;
        logic pwr_val;
        logic rst_assert;
        logic rst_clear;
        logic clk_wr;
        logic clk_ovr;
        logic clk_stop;
        logic auto_wr;
        logic auto_val;
        logic ctl_wr;
        logic ctl_val;
    } wr_cmd_t;

    function automatic logic key_match(input logic [DATA_W-1:0] word,
                                       input logic [KEY_W-1:0]  key);
        return word[KEY_LSB +: KEY_W] == key;
    endfunction

endpackage

// File: rtl/perctl_decode.sv
module perctl_decode
    import perctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output reg_sel_e          sel,
    output wr_cmd_t           cmd
);
    localparam int LAST_OFS = 6;

    always_comb begin
        if (addr <= ADDR_W'(LAST_OFS)) sel = reg_sel_e'(addr[2:0]);
        else                           sel = SEL_NONE;
    end

    always_comb begin
        cmd            = '0;
        cmd.pwr_val    = wdata[0];
        cmd.clk_ovr    = wdata[0];
        cmd.clk_stop   = wdata[1];
        cmd.auto_val   = wdata[0];
        cmd.ctl_val    = wdata[0];
        if (we) begin
            unique case (sel)
                SEL_PWR:  cmd.pwr_wr = key_match(wdata, PWR_KEY);
                SEL_RST: begin
                    cmd.rst_assert = key_match(wdata, RST_KEY) & wdata[0];
                    cmd.rst_clear  = key_match(wdata, RST_KEY) & wdata[1];
                end
                SEL_CLK:  cmd.clk_wr  = 1'b1;
                SEL_AUTO: cmd.auto_wr = 1'b1;
                SEL_CTL:  cmd.ctl_wr  = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/perctl_keyregs.sv
module perctl_keyregs
    import perctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    output logic    pwr_en,
    output logic    rst_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_en    <= 1'b0;
            rst_pulse <= 1'b0;
        end else begin
            if (cmd.pwr_wr) pwr_en <= cmd.pwr_val;
            rst_pulse <= cmd.rst_assert;
        end
    end
endmodule

// File: rtl/perctl_sticky.sv
module perctl_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)        flag <= 1'b0;
        else if (set_i) flag <= 1'b1;
        else if (clr_i) flag <= 1'b0;
    end
endmodule

// File: rtl/perctl_cfgregs.sv
module perctl_cfgregs
    import perctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_cmd_t cmd,
    input  logic    rst_pulse,
    output logic    clk_ovr,
    output logic    clk_stop,
    output logic    auto_off,
    output logic    ctl_on
);
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_ovr  <= 1'b0;
            clk_stop <= 1'b0;
            auto_off <= 1'b1;
            ctl_on   <= 1'b0;
        end else begin
            if (cmd.clk_wr) begin
                clk_ovr  <= cmd.clk_ovr;
                clk_stop <= cmd.clk_stop;
            end
            if (cmd.auto_wr) auto_off <= cmd.auto_val;
            if (rst_pulse)       ctl_on <= 1'b0;
            else if (cmd.ctl_wr) ctl_on <= cmd.ctl_val;
        end
    end
endmodule

// File: rtl/perctl_top.sv
module perctl_top
    import perctl_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [31:0]       bus_rdata,
    input  logic              periph_idle,
    input  logic              periph_auto_stop,
    input  logic              periph_ready,
    output logic              periph_rst_pulse,
    output logic              periph_on,
    output logic              clk_stop_req,
    output logic              enable_req
);
    reg_sel_e sel;
    wr_cmd_t  cmd;
    logic     pwr_en_q, sticky_q, clk_ovr_q, clk_stop_q, auto_off_q, ctl_on_q;
    logic [DATA_W-1:0] rd_word;

    perctl_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr(bus_addr), .wdata(bus_wdata), .we(bus_we), .sel(sel), .cmd(cmd)
    );

    perctl_keyregs key_i (
        .clk(clk), .rst(rst), .cmd(cmd),
        .pwr_en(pwr_en_q), .rst_pulse(periph_rst_pulse)
    );

    perctl_sticky stk_i (
        .clk(clk), .rst(rst), .set_i(periph_rst_pulse),
        .clr_i(cmd.rst_clear), .flag(sticky_q)
    );

    perctl_cfgregs cfg_i (
        .clk(clk), .rst(rst), .cmd(cmd), .rst_pulse(periph_rst_pulse),
        .clk_ovr(clk_ovr_q), .clk_stop(clk_stop_q),
        .auto_off(auto_off_q), .ctl_on(ctl_on_q)
    );

    assign periph_on    = ctl_on_q;
    assign clk_stop_req = clk_ovr_q ? clk_stop_q : periph_auto_stop;
    assign enable_req   = pwr_en_q & (~auto_off_q | ~periph_idle);

    always_comb begin
        rd_word = '0;
        unique case (sel)
            SEL_PWR:  rd_word[0] = pwr_en_q;
            SEL_STAT: rd_word[STICKY_BIT] = sticky_q;
            SEL_CLK:  rd_word[1:0] = {clk_stop_q, clk_ovr_q};
            SEL_AUTO: rd_word[0] = auto_off_q;
            SEL_CTL:  rd_word[0] = ctl_on_q;
            SEL_RDY:  rd_word[0] = periph_ready;
            default:  rd_word = '0;
        endcase
    end

    assign bus_rdata = bus_re ? rd_word : '0;
endmodule

// File: rtl/perctl_checker.sv
module perctl_checker #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic [31:0]       bus_rdata,
    input logic              pwr_en,
    input logic              rst_pulse,
    input logic              sticky,
    input logic              periph_on,
    input logic              enable_req
);
    logic rst_wr_keyed;
    assign rst_wr_keyed = bus_we && bus_addr == ADDR_W'(1) && bus_wdata[31:24] == 8'hB1;

    a_r1_pwr_needs_key: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(0) && bus_wdata[31:24] != 8'h26) |=> $stable(pwr_en));

    a_r2_no_pulse_without_key: assert property (@(posedge clk) disable iff (rst)
        !(rst_wr_keyed && bus_wdata[0]) |=> !rst_pulse);

    a_r3_pulse_follows_write: assert property (@(posedge clk) disable iff (rst)
        (rst_wr_keyed && bus_wdata[0]) |=> rst_pulse);

    a_r4_pulse_turns_off: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> !periph_on);

    a_r5_r6_pulse_sets_sticky: assert property (@(posedge clk) disable iff (rst)
        rst_pulse |=> sticky);

    a_r6_keyed_clear: assert property (@(posedge clk) disable iff (rst)
        (rst_wr_keyed && bus_wdata[1] && !rst_pulse) |=> !sticky);

    a_r8_no_req_unpowered: assert property (@(posedge clk) disable iff (rst)
        !pwr_en |-> !enable_req);

    a_r11_idle_bus_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_re |-> bus_rdata == 32'd0);

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr > ADDR_W'(6)) |-> bus_rdata == 32'd0);
endmodule

bind perctl_top perctl_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwr_en(pwr_en_q), .rst_pulse(periph_rst_pulse), .sticky(sticky_q),
    .periph_on(periph_on), .enable_req(enable_req)
);

// File: tb/perctl_top_tb.sv
`timescale 1ns/1ps
module perctl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        periph_idle = 1'b1;
    logic        periph_auto_stop = 1'b0;
    logic        periph_ready = 1'b1;
    logic        periph_rst_pulse, periph_on, clk_stop_req, enable_req;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    perctl_top #(.ADDR_W(3)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .periph_idle(periph_idle), .periph_auto_stop(periph_auto_stop),
        .periph_ready(periph_ready), .periph_rst_pulse(periph_rst_pulse),
        .periph_on(periph_on), .clk_stop_req(clk_stop_req), .enable_req(enable_req)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 32'h0,         32'h0,     4'd1},  // R1 reset value
        '{1'b0, 3'd4, 32'h0,         32'h1,     4'd8},  // R8 auto-off resets to 1
        '{1'b1, 3'd0, 32'h2500_0001, 32'h0,     4'd1},
        '{1'b0, 3'd0, 32'h0,         32'h0,     4'd1},  // R1 wrong key ignored
        '{1'b1, 3'd0, 32'h2600_0001, 32'h0,     4'd1},
        '{1'b0, 3'd0, 32'h0,         32'h1,     4'd1},  // R1 keyed, key byte reads 0
        '{1'b1, 3'd5, 32'h0000_0001, 32'h0,     4'd9},
        '{1'b0, 3'd5, 32'h0,         32'h1,     4'd9},  // R9
        '{1'b1, 3'd6, 32'hFFFF_FFFE, 32'h0,     4'd9},
        '{1'b0, 3'd6, 32'h0,         32'h1,     4'd9},  // R9 ready mirror
        '{1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0,     4'd10},
        '{1'b0, 3'd3, 32'h0,         32'h3,     4'd10}, // R10 reserved read 0
        '{1'b1, 3'd3, 32'h0,         32'h0,     4'd7},
        '{1'b0, 3'd7, 32'h0,         32'h0,     4'd10}, // R10 unmapped
        '{1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0,     4'd10},
        '{1'b0, 3'd2, 32'h0,         32'h0,     4'd5},  // R5
        '{1'b1, 3'd1, 32'hB000_0001, 32'h0,     4'd2},
        '{1'b0, 3'd2, 32'h0,         32'h0,     4'd2},  // R2 near-miss key
        '{1'b0, 3'd1, 32'h0,         32'h0,     4'd10}  // R10 reset-control reads 0
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
        bus_re = 1'b1; bus_addr = a;
        #1;
        check(bus_rdata, exp, tag);
        bus_re = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(32'(periph_rst_pulse), 32'd0, "R3 reset no pulse");
        check(32'(bus_rdata), 32'd0, "R11 re low");

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
            else           rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vec %0d", VEC[i].req, i));
        end

        // R3 R4 R5: pulse timing; periph_on is 1 from the table
        wr(3'd1, 32'hB100_0001);
        check(32'(periph_rst_pulse), 32'd1, "R3 pulse high");
        check(32'(periph_on), 32'd1, "R4 on until pulse ends");
        @(negedge clk);
        check(32'(periph_rst_pulse), 32'd0, "R3 pulse one cycle");
        check(32'(periph_on), 32'd0, "R4 on cleared");
        rd(3'd2, 32'h0001_0000, "R5 sticky set");

        wr(3'd1, 32'hB100_0000);
        check(32'(periph_rst_pulse), 32'd0, "R3 zero no pulse");

        // R6 clear behaviour
        wr(3'd1, 32'hB000_0002);
        rd(3'd2, 32'h0001_0000, "R6 clear without key");
        wr(3'd1, 32'hB100_0000);
        rd(3'd2, 32'h0001_0000, "R6 zero no clear");
        wr(3'd1, 32'hB100_0002);
        rd(3'd2, 32'h0, "R6 keyed clear");

        // R6 clear on the edge that ends a pulse
        wr(3'd1, 32'hB100_0001);
        wr(3'd1, 32'hB100_0002);
        rd(3'd2, 32'h0001_0000, "R6 set wins");

        // R7 clock request
        periph_auto_stop = 1'b1; #1;
        check(32'(clk_stop_req), 32'd1, "R7 auto follow");
        wr(3'd3, 32'h1);
        #1 check(32'(clk_stop_req), 32'd0, "R7 override run");
        wr(3'd3, 32'h3);
        periph_auto_stop = 1'b0; #1;
        check(32'(clk_stop_req), 32'd1, "R7 override stop");
        wr(3'd3, 32'h2);
        #1 check(32'(clk_stop_req), 32'd0, "R7 override off");

        // R8 enable request (power on from table)
        periph_idle = 1'b1; #1;
        check(32'(enable_req), 32'd0, "R8 idle auto-off");
        periph_idle = 1'b0; #1;
        check(32'(enable_req), 32'd1, "R8 busy");
        periph_idle = 1'b1;
        wr(3'd4, 32'h0);
        #1 check(32'(enable_req), 32'd1, "R8 auto-off cleared");
        wr(3'd0, 32'hB100_0000);
        #1 check(32'(enable_req), 32'd1, "R1 wrong key keeps power");
        wr(3'd0, 32'h2600_0000);
        #1 check(32'(enable_req), 32'd0, "R8 power off");

        // R10 unmapped write leaves state
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd5, 32'h0, "R10 unmapped write ctl");
        rd(3'd4, 32'h0, "R10 unmapped write auto");

        // block reset
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(3'd2, 32'h0, "R5 sticky after reset");
        rd(3'd4, 32'h1, "R8 auto-off after reset");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule